// File: doc/BRIEF.md
# Sequential Restoring Divider with Early Overflow Detection

This block divides an unsigned dividend of twice the divisor width by an unsigned divisor. It uses one shift-and-subtract step per quotient bit. The dividend is kept in a working register one bit wider than itself. A comparator-subtractor looks at the top divisor-width-plus-one bits of that register. In each step the divisor is subtracted if the difference does not borrow; otherwise the register is shifted left. When the block finishes, the quotient sits in the low half of the register and the remainder in the high half.

Before any quotient bit is produced, the block compares the high half of the dividend with the divisor. If the high half is not smaller than the divisor, the quotient cannot fit in the divisor width. This always happens for a zero divisor. In that case the block raises its overflow flag and goes back to idle without changing the loaded register.

A caller holds the operands, pulses `start` while `ready` is high, and waits for `ready` to return. The operands are captured at the start cycle, so the inputs may change freely while the block is busy.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `ready` is 1, `overflow` is 0, and `quotient` and `remainder` are 0.
- R2: `start` sampled high while `ready` is high captures both operands and clears `overflow`; `ready` is 0 from the next cycle on.
- R3: If the upper half of the dividend (bits 2N-1..N) is greater than or equal to the divisor, `overflow` becomes 1 and `ready` is low for exactly one cycle.
- R4: Without overflow, the block ends with `quotient` equal to the integer quotient and `remainder` equal to dividend modulo divisor.
- R5: Without overflow, `ready` stays low for exactly N + 1 + k cycles, where k is the number of 1 bits among quotient bits N-1..1. Each such bit costs a subtract cycle in addition to its shift cycle.
- R6: While `ready` is low, `start` and any change on the operand inputs have no effect on the result.
- R7: While idle with `start` low, `quotient`, `remainder` and `overflow` hold their values whatever the operand inputs do.
- R8: A divisor of zero is always reported as overflow.
- R9: After an overflow, `remainder` shows dividend bits 2N-1..N and `quotient` shows dividend bits N-1..0, unchanged from the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division (honoured only while ready) |
| dividend | input | 2*N_W | Unsigned dividend |
| divisor | input | N_W | Unsigned divisor |
| quotient | output | N_W | Low half of the working register |
| remainder | output | N_W | Bits 2N-1..N of the working register |
| overflow | output | 1 | Quotient would not fit, or the divisor is zero |
| ready | output | 1 | Idle, result valid |

## Verification
Each start is applied on a falling edge and taken on the next rising edge. From the falling edge after that rising edge, the bench counts how many falling edges see `ready` low. That count is compared with the cycle count expected for the operands: one cycle for an overflow, and N + 1 plus the 1 bits in quotient bits N-1..1 otherwise. Results are sampled only on the first falling edge where `ready` is high again. The idle-hold and busy-ignore tests sample on falling edges too, after the inputs have been disturbed across several rising edges.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_STEP  = 2'd2,
      ST_LAST  = 2'd3
   } rdiv_state_e;

   localparam int CMP_BORROW  = 0;
   localparam int CMP_COMPARE = 1;

endpackage

// File: rtl/rdiv_cmpsub.sv
module rdiv_cmpsub #(
   parameter int N_W       = 4,
   parameter int CMP_STYLE = 0
) (
   input  logic [N_W:0]   upper,
   input  logic [N_W-1:0] dvs,
   output logic           fit,
   output logic [N_W:0]   diff
);
   localparam int UW = N_W + 1;

   if (N_W < 2) begin : g_bad_width
      $error("rdiv_cmpsub: N_W must be at least 2");
   end
   if (CMP_STYLE != rdiv_pkg::CMP_BORROW && CMP_STYLE != rdiv_pkg::CMP_COMPARE) begin : g_bad_style
      $error("rdiv_cmpsub: unknown CMP_STYLE");
   end

   logic [UW-1:0] dvs_ext;
   assign dvs_ext = {1'b0, dvs};

   if (CMP_STYLE == rdiv_pkg::CMP_BORROW) begin : g_borrow
      logic [UW:0] wide;
      assign wide = {1'b0, upper} - {1'b0, dvs_ext};
      assign fit  = ~wide[UW];
      assign diff = wide[UW-1:0];
   end else begin : g_compare
      assign fit  = (upper >= dvs_ext);
      assign diff = upper - dvs_ext;
   end

endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath #(
   parameter int N_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic             sh,
   input  logic             su,
   input  logic [2*N_W-1:0] dividend,
   input  logic [N_W-1:0]   divisor,
   input  logic [N_W:0]     diff,
   output logic [N_W:0]     upper,
   output logic [N_W-1:0]   dvs_q,
   output logic [N_W-1:0]   quo,
   output logic [N_W-1:0]   rem
);
   localparam int DW = 2 * N_W;
   localparam int XW = DW + 1;

   logic [XW-1:0] work_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q <= '0;
         dvs_q  <= '0;
      end else if (ld) begin
         work_q <= {1'b0, dividend};
         dvs_q  <= divisor;
      end else if (su) begin
         work_q[XW-1:N_W] <= diff;
         work_q[0]        <= 1'b1;
      end else if (sh) begin
         work_q <= {work_q[XW-2:0], 1'b0};
      end
   end

   assign upper = work_q[XW-1:N_W];
   assign quo   = work_q[N_W-1:0];
   assign rem   = work_q[DW-1:N_W];

   AST_SHIFT_EMPTIES_LSB: assert property (@(posedge clk) disable iff (!rst_n) (sh && !su && !ld) |=> (work_q[0] == 1'b0)); // R4
   AST_SUB_MARKS_LSB: assert property (@(posedge clk) disable iff (!rst_n) (su && !ld) |=> (work_q[0] == 1'b1)); // R4
   AST_DIVISOR_HELD: assert property (@(posedge clk) disable iff (!rst_n) !ld |=> $stable(dvs_q)); // R6

endmodule

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
   import rdiv_pkg::*;
#(
   parameter int N_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic fit,
   output logic ld,
   output logic sh,
   output logic su,
   output logic ovf,
   output logic ready
);
   localparam int CNT_W = $clog2(N_W) + 1;
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(N_W - 1);

   rdiv_state_e   state_q, state_d;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      state_d = state_q;
      ld = 1'b0;
      sh = 1'b0;
      su = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               ld      = 1'b1;
               state_d = ST_CHECK;
            end
         end
         ST_CHECK: begin
            if (fit) begin
               state_d = ST_IDLE;
            end else begin
               sh      = 1'b1;
               state_d = ST_STEP;
            end
         end
         ST_STEP: begin
            if (fit) begin
               su = 1'b1;
            end else begin
               sh = 1'b1;
               if (cnt_q == LAST_STEP) state_d = ST_LAST;
            end
         end
         ST_LAST: begin
            su      = fit;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         ovf     <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_CHECK) cnt_q <= CNT_W'(1);
         else if (state_q == ST_STEP && !fit) cnt_q <= cnt_q + CNT_W'(1);
         if (ld) ovf <= 1'b0;
         else if (state_q == ST_CHECK && fit) ovf <= 1'b1;
      end
   end

   assign ready = (state_q == ST_IDLE);

   AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (ready && start) |=> (!ready && !ovf)); // R2
   AST_OVF_FROM_CHECK: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf) |-> (ready && $past(state_q == ST_CHECK))); // R3
   AST_IDLE_HOLDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (ready && !start) |=> $stable(ovf)); // R7
   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n) $countones({ld, sh, su}) <= 1); // R4

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
   parameter int N_W       = 4,
   parameter int CMP_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [2*N_W-1:0] dividend,
   input  logic [N_W-1:0]   divisor,
   output logic [N_W-1:0]   quotient,
   output logic [N_W-1:0]   remainder,
   output logic             overflow,
   output logic             ready
);
   logic           ld, sh, su, fit;
   logic [N_W:0]   upper, diff;
   logic [N_W-1:0] dvs_q;

   rdiv_ctrl #(.N_W(N_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .fit(fit),
      .ld(ld), .sh(sh), .su(su), .ovf(overflow), .ready(ready)
   );

   rdiv_cmpsub #(.N_W(N_W), .CMP_STYLE(CMP_STYLE)) i_cmpsub (
      .upper(upper), .dvs(dvs_q), .fit(fit), .diff(diff)
   );

   rdiv_datapath #(.N_W(N_W)) i_dp (
      .clk(clk), .rst_n(rst_n), .ld(ld), .sh(sh), .su(su),
      .dividend(dividend), .divisor(divisor), .diff(diff),
      .upper(upper), .dvs_q(dvs_q), .quo(quotient), .rem(remainder)
   );

   AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n) ($rose(ready) && !overflow) |-> (remainder < dvs_q)); // R4
   AST_ZERO_DIVISOR_OVF: assert property (@(posedge clk) disable iff (!rst_n) ($rose(ready) && dvs_q == '0) |-> overflow); // R8
   AST_IDLE_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (ready && !start) |=> ($stable(quotient) && $stable(remainder))); // R7

endmodule

// File: tb/test_restoring_divider.sv
module test_restoring_divider;
   localparam int CLK_PERIOD = 10;
   localparam int N = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [2*N-1:0] dividend = '0;
   logic [N-1:0]   divisor = '0;
   logic [N-1:0]   quotient, remainder;
   logic           overflow, ready;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   restoring_divider #(.N_W(N)) i_restoring_divider (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
      .quotient(quotient), .remainder(remainder), .overflow(overflow), .ready(ready)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Runs one division; disturb=1 pulses start and changes operands mid-run (R6)
   task automatic run_div(input int a, input int b, input bit disturb);
      int  eq, er, elat, busy;
      bit  eovf;
      eovf = ((a >> N) >= b);
      eq   = eovf ? (a & 15) : a / b;
      er   = eovf ? (a >> N) : a % b;
      elat = eovf ? 1 : N + 1 + $countones(eq[N-1:1]);
      @(negedge clk);
      dividend = a[2*N-1:0];
      divisor  = b[N-1:0];
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(!ready && !overflow, "R2 busy after start", {ready, overflow}, 0);
      busy = 1;
      for (int i = 0; i < 64; i++) begin
         if (disturb && i == 1) begin
            start    = 1'b1;
            dividend = ~a[2*N-1:0];
            divisor  = ~b[N-1:0];
         end
         if (disturb && i == 3) start = 1'b0;
         @(negedge clk);
         if (ready) break;
         busy++;
      end
      start = 1'b0;
      if (eovf) begin
         check(overflow == 1'b1, (b == 0) ? "R8 zero divisor overflow" : "R3 overflow flag", overflow, 1);
         check(busy == elat, "R3 overflow latency", busy, elat);
         check(quotient == eq && remainder == er, "R9 register untouched", {remainder, quotient}, (er << N) | eq);
      end else begin
         check(overflow == 1'b0, "R4 no overflow", overflow, 0);
         check(quotient == eq, disturb ? "R6 quotient" : "R4 quotient", quotient, eq);
         check(remainder == er, disturb ? "R6 remainder" : "R4 remainder", remainder, er);
         check(busy == elat, "R5 latency", busy, elat);
      end
   endtask

   task automatic idle_hold();
      logic [N-1:0] q0, r0;
      logic         v0;
      q0 = quotient; r0 = remainder; v0 = overflow;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         dividend = 8'(i * 37 + 5);
         divisor  = 4'(i);
      end
      @(negedge clk);
      check(quotient == q0 && remainder == r0 && overflow == v0, "R7 idle hold",
            {overflow, remainder, quotient}, {v0, r0, q0});
   endtask

   task automatic reset_state();
      @(negedge clk);
      check(ready == 1'b1 && overflow == 1'b0, "R1 reset flags", {ready, overflow}, 2);
      check(quotient == 0 && remainder == 0, "R1 reset result", {remainder, quotient}, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      reset_state();
      run_div(135, 13, 1'b0);
      run_div(239, 15, 1'b0);
      run_div(7, 9, 1'b0);
      run_div(15, 1, 1'b0);
      run_div(100, 7, 1'b0);
      run_div(255, 15, 1'b0);
      run_div(16, 1, 1'b0);
      idle_hold();
      run_div(0, 0, 1'b0);
      run_div(200, 0, 1'b0);
      run_div(0, 5, 1'b0);
      run_div(135, 13, 1'b1);
      run_div(225, 9, 1'b1);
      idle_hold();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule